// File: doc/BRIEF.md
# Collision Backoff Slot Timer

This block times the wait after a collision in a half-duplex Ethernet MAC. When a collision is reported, it takes a pseudo-random slot count from a free-running linear feedback shift register. The count is masked to a window that widens with each successive collision, up to a configured ceiling, which gives truncated binary exponential backoff. The block then counts that many slot times on the line-time tick. At the end it emits a one-cycle pulse telling the transmit side that a retry may start.

The slot is 512 bit times at 10 and 100 Mb/s and 512 byte times at gigabit rate. It is measured in bit times in both cases and trimmed by a signed 10-bit offset that absorbs the PHY round-trip latency. The tick input marks one bit time at the lower rates and one byte time at gigabit rate, so each gigabit tick accounts for 8 bit times. Software may reload the low byte of the shift register at any moment. Speed, trim and ceiling are expected to stay fixed outside reset. The reset input is asynchronous and active-low, and it is assumed to be released in step with the clock.

Top module: `bkoff_slot_timer`

## Requirements
- R1: While reset is asserted and right after it, `bkoff_done` is low, the shift register holds 16'hACE1 and the collision history is empty, so the next collision counts as the first.
- R2: The 16-bit shift register steps once on every clock. It shifts toward the MSB, and the new bit 0 is bit15 XOR bit13 XOR bit12 XOR bit10.
- R3: A cycle with `seed_wr` high loads the register with the upper byte of its stepped value and `seed_val` in the low byte. If that result is all zero, the register holds 16'h0001 instead.
- R4: On a collision, the slot count is the low w bits of the register value in that cycle. Here w = min(n, max_exp, 10), where n is the number of collisions since reset or the last success, this one included. Values of `max_exp` above 10 act as 10.
- R5: `tx_ok` clears the collision history. A collision in the same cycle counts as the first one (n = 1).
- R6: A slot lasts L = base + `slot_trim` bit times, with `slot_trim` read as two's complement. The base is 512 when `gig_mode` is low and 8*512 when it is high. A slot takes L ticks at the lower rates and ceil(L/8) ticks at gigabit rate.
- R7: When L computes to less than 1, it is taken as 1 bit time, so every slot ends after exactly one tick.
- R8: `bkoff_done` is high for exactly one cycle, in the cycle after the edge that samples the final tick. With a zero slot count, it is high in the cycle right after the collision.
- R9: A collision while a backoff is running discards it and starts a new one, and a tick in a collision cycle is not counted.
- R10: A seed write during a running backoff leaves that backoff's length unchanged. It only affects later draws.
- R11: Without a collision in progress, ticks never raise `bkoff_done`. During a backoff, only cycles with `tick` high advance it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| gig_mode | input | 1 | 1 = gigabit (byte-time ticks, 8*base slot) |
| slot_trim | input | TRIM_W | Signed slot offset in bit times |
| max_exp | input | EXP_W | Backoff exponent ceiling |
| seed_wr | input | 1 | Load low byte of the shift register |
| seed_val | input | SEED_W | Value for the low byte |
| tx_ok | input | 1 | Successful transmit, clears collision history |
| coll | input | 1 | Collision pulse, starts a backoff |
| tick | input | 1 | One bit time (or byte time at gigabit) elapsed |
| bkoff_done | output | 1 | One-cycle pulse when the backoff expires |

## Verification
The bench builds the block with a base slot of 32 bit times instead of 512, so the slot is 32 ticks at the lower rates and 32 at gigabit rate (256 bit times in byte ticks). With that base, even a maximum window of 1023 slots fits in a short run when the trim drives the slot down to one tick. Because the base is small, the 10-bit trim is large enough relative to it to reach the clamp at both speeds and to exercise the ceil(L/8) rounding at gigabit rate. All other parameters keep their defaults, so the 16-bit register, the 8-bit seed and the exponent limit of 10 are exercised as shipped.

// File: rtl/bkoff_pkg.sv
package bkoff_pkg;
  typedef enum logic {
    BK_IDLE = 1'b0,
    BK_WAIT = 1'b1
  } bk_state_e;
endpackage

// File: rtl/bkoff_lfsr.sv
module bkoff_lfsr #(
  parameter int          W      = 16,
  parameter int          SEED_W = 8,
  parameter logic [W-1:0] TAPS  = 16'hB400,
  parameter logic [W-1:0] INIT  = 16'hACE1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              seed_wr,
  input  logic [SEED_W-1:0] seed_val,
  output logic [W-1:0]      value
);
  logic [W-1:0] st_q, st_d, stepped, merged;

  always_comb begin
    stepped = {st_q[W-2:0], ^(st_q & TAPS)};
    merged  = seed_wr ? {stepped[W-1:SEED_W], seed_val} : stepped;
    st_d    = (merged == '0) ? W'(1) : merged;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= INIT;
    else        st_q <= st_d;
  end

  assign value = st_q;

  // R3
  seed_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    seed_wr |=> (st_q[SEED_W-1:0] == $past(seed_val)) || (st_q == W'(1)));
  // R2
  lfsr_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    st_q != '0);
endmodule

// File: rtl/bkoff_slot_len.sv
module bkoff_slot_len #(
  parameter int BASE   = 512,
  parameter int TRIM_W = 10,
  parameter int LEN_W  = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              gig_mode,
  input  logic [TRIM_W-1:0] slot_trim,
  output logic [LEN_W-1:0]  len_bits,
  output logic [3:0]        step_bits
);
  localparam int GIG_BITS = BASE * 8;

  logic signed [LEN_W:0] base_s, trim_s, raw;

  always_comb begin
    base_s    = gig_mode ? (LEN_W+1)'(GIG_BITS) : (LEN_W+1)'(BASE);
    trim_s    = {{(LEN_W+1-TRIM_W){slot_trim[TRIM_W-1]}}, slot_trim};
    raw       = base_s + trim_s;
    len_bits  = (raw[LEN_W] || (raw == '0)) ? LEN_W'(1) : raw[LEN_W-1:0];
    step_bits = gig_mode ? 4'd8 : 4'd1;
  end

  // R7
  len_clamp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!gig_mode && slot_trim[TRIM_W-1] && (slot_trim <= TRIM_W'(-BASE)))
      |-> (len_bits == LEN_W'(1)));
endmodule

// File: rtl/bkoff_draw.sv
module bkoff_draw #(
  parameter int LFSR_W  = 16,
  parameter int EXP_LIM = 10,
  parameter int EXP_W   = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               coll,
  input  logic               tx_ok,
  input  logic [EXP_W-1:0]   max_exp,
  input  logic [LFSR_W-1:0]  rnd,
  output logic [EXP_LIM-1:0] slots
);
  logic [EXP_W-1:0]   att_q, att_d, hist, nth, lim, width;
  logic               att_en;
  logic [EXP_LIM-1:0] mask;

  always_comb begin
    hist   = tx_ok ? '0 : att_q;
    nth    = (hist >= EXP_W'(EXP_LIM)) ? EXP_W'(EXP_LIM) : hist + 1'b1;
    lim    = (max_exp > EXP_W'(EXP_LIM)) ? EXP_W'(EXP_LIM) : max_exp;
    width  = (nth < lim) ? nth : lim;
    att_en = coll | tx_ok;
    att_d  = coll ? nth : hist;
  end

  for (genvar i = 0; i < EXP_LIM; i++) begin : g_mask
    assign mask[i] = (EXP_W'(i) < width);
  end

  assign slots = rnd[EXP_LIM-1:0] & mask;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      att_q <= '0;
    else if (att_en) att_q <= att_d;
  end

  // R5
  hist_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_ok && !coll) |=> (att_q == '0));
  // R4
  first_draw_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (coll && (tx_ok || att_q == '0)) |-> (slots <= EXP_LIM'(1)));
  // R4
  hist_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    att_q <= EXP_W'(EXP_LIM));
endmodule

// File: rtl/bkoff_counter.sv
module bkoff_counter
  import bkoff_pkg::*;
#(
  parameter int CNT_W = 10,
  parameter int LEN_W = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             coll,
  input  logic [CNT_W-1:0] slots,
  input  logic             tick,
  input  logic [LEN_W-1:0] len_bits,
  input  logic [3:0]       step_bits,
  output logic             done
);
  bk_state_e        st_q, st_d;
  logic [CNT_W-1:0] rem_q, rem_d;
  logic [LEN_W-1:0] acc_q, acc_d;
  logic [LEN_W:0]   acc_nx;
  logic             done_q, done_d, slot_end;

  always_comb begin
    acc_nx   = {1'b0, acc_q} + (LEN_W+1)'(step_bits);
    slot_end = acc_nx >= {1'b0, len_bits};
    st_d     = st_q;
    rem_d    = rem_q;
    acc_d    = acc_q;
    done_d   = 1'b0;
    if (coll) begin
      acc_d = '0;
      rem_d = slots;
      if (slots == '0) begin
        st_d   = BK_IDLE;
        done_d = 1'b1;
      end else begin
        st_d = BK_WAIT;
      end
    end else if (st_q == BK_WAIT && tick) begin
      if (slot_end) begin
        acc_d = '0;
        rem_d = rem_q - 1'b1;
        if (rem_q == CNT_W'(1)) begin
          st_d   = BK_IDLE;
          done_d = 1'b1;
        end
      end else begin
        acc_d = acc_nx[LEN_W-1:0];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= BK_IDLE;
      rem_q  <= '0;
      acc_q  <= '0;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      rem_q  <= rem_d;
      acc_q  <= acc_d;
      done_q <= done_d;
    end
  end

  assign done = done_q;

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && !coll) |=> !done_q);
  // R11
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == BK_IDLE && !coll) |=> !done_q);
  // R11
  hold_no_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == BK_WAIT && !coll && !tick) |=> ($stable(acc_q) && $stable(rem_q)));
  // R9
  restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    coll |=> (acc_q == '0));
  // R6
  acc_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == BK_WAIT) |-> (acc_q < len_bits && rem_q != '0));
endmodule

// File: rtl/bkoff_slot_timer.sv
module bkoff_slot_timer #(
  parameter int              BASE_SLOT_BITS = 512,
  parameter int              TRIM_W         = 10,
  parameter int              EXP_LIM        = 10,
  parameter int              LFSR_W         = 16,
  parameter int              SEED_W         = 8,
  parameter logic [LFSR_W-1:0] LFSR_TAPS    = 16'hB400,
  parameter logic [LFSR_W-1:0] LFSR_INIT    = 16'hACE1,
  localparam int             EXP_W          = $clog2(EXP_LIM + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              gig_mode,
  input  logic [TRIM_W-1:0] slot_trim,
  input  logic [EXP_W-1:0]  max_exp,
  input  logic              seed_wr,
  input  logic [SEED_W-1:0] seed_val,
  input  logic              tx_ok,
  input  logic              coll,
  input  logic              tick,
  output logic              bkoff_done
);
  localparam int LEN_W = $clog2(BASE_SLOT_BITS * 8 + 2 ** (TRIM_W - 1)) + 1;

  logic [LFSR_W-1:0]  rnd;
  logic [EXP_LIM-1:0] slots;
  logic [LEN_W-1:0]   len_bits;
  logic [3:0]         step_bits;

  bkoff_lfsr #(.W(LFSR_W), .SEED_W(SEED_W), .TAPS(LFSR_TAPS), .INIT(LFSR_INIT)) u_lfsr (
    .clk(clk), .rst_n(rst_n), .seed_wr(seed_wr), .seed_val(seed_val), .value(rnd));

  bkoff_slot_len #(.BASE(BASE_SLOT_BITS), .TRIM_W(TRIM_W), .LEN_W(LEN_W)) u_len (
    .clk(clk), .rst_n(rst_n), .gig_mode(gig_mode), .slot_trim(slot_trim),
    .len_bits(len_bits), .step_bits(step_bits));

  bkoff_draw #(.LFSR_W(LFSR_W), .EXP_LIM(EXP_LIM), .EXP_W(EXP_W)) u_draw (
    .clk(clk), .rst_n(rst_n), .coll(coll), .tx_ok(tx_ok), .max_exp(max_exp),
    .rnd(rnd), .slots(slots));

  bkoff_counter #(.CNT_W(EXP_LIM), .LEN_W(LEN_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .coll(coll), .slots(slots), .tick(tick),
    .len_bits(len_bits), .step_bits(step_bits), .done(bkoff_done));
endmodule

// File: tb/bkoff_slot_timer_test.sv
module bkoff_slot_timer_test;
  localparam int BASE = 32;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       gig_mode = 1'b0;
  logic [9:0] slot_trim = '0;
  logic [3:0] max_exp = 4'd10;
  logic       seed_wr = 1'b0;
  logic [7:0] seed_val = '0;
  logic       tx_ok = 1'b0;
  logic       coll = 1'b0;
  logic       tick = 1'b0;
  logic       bkoff_done;

  int total = 0;
  int bad = 0;
  int m_hist = 0;
  logic [15:0] m_lfsr;

  always #4 clk = ~clk;

  bkoff_slot_timer #(.BASE_SLOT_BITS(BASE)) uut (
    .clk(clk), .rst_n(rst_n), .gig_mode(gig_mode), .slot_trim(slot_trim),
    .max_exp(max_exp), .seed_wr(seed_wr), .seed_val(seed_val), .tx_ok(tx_ok),
    .coll(coll), .tick(tick), .bkoff_done(bkoff_done));

  // Reference register model from R1, R2, R3
  function automatic logic [15:0] ref_next(logic [15:0] s, logic wr, logic [7:0] sv);
    logic [15:0] n;
    n = {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
    if (wr) n = {n[15:8], sv};
    if (n == 16'h0) n = 16'h0001;
    return n;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) m_lfsr <= 16'hACE1;
    else        m_lfsr <= ref_next(m_lfsr, seed_wr, seed_val);
  end

  function automatic int ticks_per_slot(logic g, logic [9:0] tr);
    int len;
    len = (g ? BASE * 8 : BASE) + $signed(tr);
    if (len < 1) len = 1;
    return g ? (len + 7) / 8 : len;
  endfunction

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic pulse_txok();
    @(negedge clk);
    tx_ok = 1'b1;
    @(negedge clk);
    tx_ok = 1'b0;
    m_hist = 0;
  endtask

  task automatic write_seed(input logic [7:0] v);
    @(negedge clk);
    seed_wr = 1'b1;
    seed_val = v;
  endtask

  // Starts a backoff and checks when done rises. exp_k < 0 disables the
  // directed slot-count check. seed_at >= 0 writes a seed mid-run (R10).
  task automatic do_backoff(input bit with_ok, input int seed_at, input int tick_pct,
                            input int exp_k, input string req);
    int n, lim, w, k, t_need, ticks, cyc, early;
    bit fin;
    @(negedge clk);
    seed_wr = 1'b0;
    n = with_ok ? 1 : ((m_hist + 1 > 10) ? 10 : m_hist + 1);
    m_hist = n;
    lim = (max_exp > 10) ? 10 : int'(max_exp);
    w = (n < lim) ? n : lim;
    k = int'(m_lfsr) & ((1 << w) - 1);
    if (exp_k >= 0) chk(k == exp_k, req, "drawn slot count", k, exp_k);
    t_need = k * ticks_per_slot(gig_mode, slot_trim);
    coll = 1'b1;
    tx_ok = with_ok;
    tick = ($urandom % 100) < 50;
    ticks = 0; cyc = 0; early = 0; fin = 0;
    while (!fin) begin
      @(negedge clk);
      coll = 1'b0; tx_ok = 1'b0; seed_wr = 1'b0;
      if (ticks == t_need) begin
        chk(bkoff_done == 1'b1, req, "done at final tick", int'(bkoff_done), 1);
        tick = 1'b0;
        fin = 1;
      end else begin
        if (bkoff_done) early++;
        tick = (($urandom % 100) < tick_pct);
        if (tick) ticks++;
        if (cyc == seed_at) begin
          seed_wr = 1'b1;
          seed_val = 8'($urandom);
        end
        cyc++;
        if (cyc > 60000) begin
          chk(1'b0, req, "backoff never completed", cyc, t_need);
          fin = 1;
        end
      end
    end
    chk(early == 0, "R11", "early done cycles", early, 0);
    @(negedge clk);
    chk(bkoff_done == 1'b0, "R8", "done width", int'(bkoff_done), 0);
  endtask

  // Starts a backoff and abandons it after ncyc ticking cycles.
  task automatic start_partial(input int ncyc, input string req);
    int n;
    @(negedge clk);
    seed_wr = 1'b0;
    n = (m_hist + 1 > 10) ? 10 : m_hist + 1;
    m_hist = n;
    coll = 1'b1;
    tick = 1'b1;
    for (int i = 0; i < ncyc; i++) begin
      @(negedge clk);
      coll = 1'b0;
      chk(bkoff_done == 1'b0, req, "done during partial run", int'(bkoff_done), 0);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk(bkoff_done == 1'b0, "R1", "done in reset", int'(bkoff_done), 0);
    rst_n = 1'b1;

    // R11: ticks alone never raise done
    tick = 1'b1;
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      chk(bkoff_done == 1'b0, "R11", "idle with ticks", int'(bkoff_done), 0);
    end
    tick = 1'b0;

    // R1 R2: first draws after reset follow the register model
    do_backoff(1'b0, -1, 100, -1, "R1");
    do_backoff(1'b0, -1, 100, -1, "R2");

    // R3: seed low byte sets the first-collision draw
    pulse_txok();
    write_seed(8'h01);
    do_backoff(1'b0, -1, 100, 1, "R3");
    pulse_txok();
    write_seed(8'hFE);
    do_backoff(1'b0, -1, 100, 0, "R3");

    // R6: gigabit slot lengths, with rounding up
    gig_mode = 1'b1; slot_trim = 10'd0;
    pulse_txok(); write_seed(8'h01);
    do_backoff(1'b0, -1, 70, 1, "R6");
    slot_trim = 10'd5;
    pulse_txok(); write_seed(8'h03);
    do_backoff(1'b0, -1, 100, 1, "R6");
    gig_mode = 1'b0; slot_trim = 10'h3FD;
    pulse_txok(); write_seed(8'h01);
    do_backoff(1'b0, -1, 60, 1, "R6");

    // R7: clamp at both speeds
    slot_trim = 10'h200;
    pulse_txok(); write_seed(8'h01);
    do_backoff(1'b0, -1, 100, 1, "R7");
    gig_mode = 1'b1;
    do_backoff(1'b0, -1, 100, -1, "R7");
    gig_mode = 1'b0; slot_trim = 10'h3E0;
    do_backoff(1'b0, -1, 100, -1, "R7");

    // R4: ceiling above 10 acts as 10 across many collisions
    max_exp = 4'd15;
    pulse_txok();
    for (int i = 0; i < 12; i++) do_backoff(1'b0, -1, 100, -1, "R4");
    max_exp = 4'd0;
    do_backoff(1'b0, -1, 100, 0, "R4");
    max_exp = 4'd10;

    // R5: success in the same cycle as a collision
    write_seed(8'hFF);
    do_backoff(1'b1, -1, 100, 1, "R5");

    // R9: restart while running
    slot_trim = 10'd0;
    pulse_txok(); write_seed(8'h01);
    start_partial(10, "R9");
    do_backoff(1'b0, -1, 100, -1, "R9");

    // R10: seed write in the middle of a run
    pulse_txok(); write_seed(8'h01);
    do_backoff(1'b0, 5, 100, 1, "R10");

    // R1: reset in the middle of a run
    pulse_txok(); write_seed(8'h01);
    start_partial(6, "R1");
    rst_n = 1'b0;
    tick = 1'b0;
    @(negedge clk);
    chk(bkoff_done == 1'b0, "R1", "done under reset", int'(bkoff_done), 0);
    rst_n = 1'b1;
    m_hist = 0;
    do_backoff(1'b0, -1, 100, -1, "R1");

    // Random mix
    for (int t = 0; t < 40; t++) begin
      gig_mode = 1'($urandom % 2);
      slot_trim = 10'(int'($urandom % 81) - 40);
      max_exp = 4'($urandom % 6);
      if (($urandom % 5) == 0) pulse_txok();
      do_backoff(($urandom % 10) == 0, (($urandom % 3) == 0) ? int'($urandom % 6) : -1,
                 75, -1, "R4");
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule